// File: doc/BRIEF.md
# NAND Internal Page Move Sequencer

This block is the host-side engine that relocates one page inside a NAND flash device without moving the page data across the host bus. After a start request it issues a source read that loads the page into the device's internal register and waits out the array busy time on the ready/busy line. It then opens a program to the destination address, optionally patches a small number of bytes in that register, and commits the program. When the program busy time ends it reads the program status and, in error-detection mode, the separate error-detection status. Each result is reported as pass or fail together with a one-cycle completion pulse.

Replacement bytes come from the host one at a time. The sequencer presents an index and samples the column and data byte that the host returns for it. In error-detection mode the device accepts only one write to a given column per move, so the sequencer keeps track of the columns it has already patched. It refuses a repeat to the same column and flags it. A programmable limit bounds every busy wait. If ready/busy stays low for that many cycles, the move stops with a timeout flag.

Top module: `nand_move_seq`

## Requirements
- R1: A move begins with a command cycle carrying 0x00, then five address cycles carrying the source address least significant byte first (bits 7:0 first), then a command cycle carrying 0x35. During a command cycle CLE is high, during an address cycle ALE is high, and during a data cycle both are low. Every write cycle is latched by one rising edge of WE#.
- R2: After each confirm command (0x35 or 0x10), no WE# or RE# strobe occurs until the ready/busy input has been seen high after a fixed settle delay.
- R3: The program phase sends command 0x85, then the five destination address bytes least significant first, then the patches, then command 0x10.
- R4: Each patch k (k from 0 to patch_cnt_i-1, with the index shown on patch_idx_o) is sent as command 0x85, two address cycles carrying patch_col_i low byte first, and one data cycle carrying patch_byte_i.
- R5: With edc_en_i high, a patch whose column equals the column of an earlier patch sent in the same move is not sent, and dup_err_o is set. With edc_en_i low, repeated columns are sent and dup_err_o stays 0.
- R6: After the program busy time the block sends command 0x70 and performs one read cycle. prog_fail_o takes bit 0 of the byte read (1 = fail).
- R7: With edc_en_i high, the block then sends command 0x7B and performs one read cycle, and edc_fail_o takes bit 0 of that byte. With edc_en_i low, neither 0x7B nor a second read is issued, and edc_fail_o is 0.
- R8: If ready/busy stays low for tmo_limit_i consecutive polled cycles, the move ends with no further bus cycles, and tmo_err_o, prog_fail_o and edc_fail_o are all 1.
- R9: done_o is high for exactly one cycle at the end of a move. The four result flags keep their values until the next accepted start.
- R10: CLE and ALE are never high together, WE# and RE# are never low together, and the I/O output enable is low whenever RE# is low.
- R11: After reset the block is idle: busy_o and done_o are 0, WE# and RE# are high, and CLE, ALE and the output enable are low.
- R12: A start request while busy_o is high is ignored, and the running move keeps its latched addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted when idle |
| src_addr_i | input | 40 | Source column and row address |
| dst_addr_i | input | 40 | Destination column and row address |
| edc_en_i | input | 1 | Error-detection mode enable |
| patch_cnt_i | input | 3 | Number of replacement bytes (0 to 4) |
| patch_idx_o | output | 2 | Index of the patch being requested |
| patch_col_i | input | 16 | Column of the indexed patch |
| patch_byte_i | input | 8 | Data byte of the indexed patch |
| tmo_limit_i | input | 16 | Busy timeout limit in cycles, at least 1 |
| busy_o | output | 1 | Move in progress |
| done_o | output | 1 | One-cycle completion pulse |
| prog_fail_o | output | 1 | Program status fail |
| edc_fail_o | output | 1 | Error-detection status fail |
| tmo_err_o | output | 1 | Busy timeout occurred |
| dup_err_o | output | 1 | Repeated patch column refused |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_io_o | output | 8 | I/O bus output data |
| nand_io_oe_o | output | 1 | I/O bus output enable |
| nand_io_i | input | 8 | I/O bus input data |
| nand_rb_ni | input | 1 | Ready/busy, low while busy |

## Verification
The assertions assume that the ready/busy line and the status byte change only in step with the clock. They also assume that patch_col_i and patch_byte_i are a pure function of patch_idx_o, so the values seen at selection time are the values sent. The bench's device model meets both assumptions: it updates ready/busy one time unit after a clock edge, and it looks patch values up from the current vector by index. Timeout limits are chosen well away from the modelled busy lengths, so each vector's outcome does not depend on an off-by-one boundary.

// File: rtl/nand_move_pkg.sv
package nand_move_pkg;

  typedef enum logic [1:0] {
    BUS_CMD  = 2'd0,
    BUS_ADDR = 2'd1,
    BUS_DIN  = 2'd2,
    BUS_RD   = 2'd3
  } bus_kind_e;

  localparam logic [7:0] OP_SRC_LOAD   = 8'h00;
  localparam logic [7:0] OP_SRC_COMMIT = 8'h35;
  localparam logic [7:0] OP_DST_OPEN   = 8'h85;
  localparam logic [7:0] OP_DST_COMMIT = 8'h10;
  localparam logic [7:0] OP_PROG_STAT  = 8'h70;
  localparam logic [7:0] OP_EDC_STAT   = 8'h7B;

  // Byte idx of a little-endian multi-byte value (byte 0 leaves first).
  function automatic logic [7:0] pick_byte(input logic [63:0] val, input int unsigned idx);
    return val[idx*8 +: 8];
  endfunction

  // Status byte decode: bit 0 high means the operation failed.
  function automatic logic stat_fail(input logic [7:0] stat);
    return stat[0];
  endfunction

endpackage

// File: rtl/nand_bus_cycle.sv
module nand_bus_cycle
  import nand_move_pkg::*;
#(
  parameter int T_WL  = 2,
  parameter int T_WH  = 2,
  parameter int T_WHR = 3,
  parameter int T_RL  = 2,
  parameter int T_RH  = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  bus_kind_e   kind_i,
  input  logic [7:0]  byte_i,
  output logic        done_o,
  output logic        idle_o,
  output logic [7:0]  rd_byte_o,
  output logic        cle_o,
  output logic        ale_o,
  output logic        we_no,
  output logic        re_no,
  output logic [7:0]  io_o,
  output logic        io_oe_o,
  input  logic [7:0]  io_i
);

  localparam int CW = $clog2(T_WL + T_WH + T_WHR + T_RL + T_RH + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_PRE, PH_LOW, PH_HIGH} phase_e;

  phase_e     ph_q;
  logic [CW-1:0] cnt_q;
  bus_kind_e  kind_q;
  logic [7:0] byte_q;
  logic [7:0] rd_q;
  logic       is_rd;
  logic       last;
  int unsigned len;

  assign is_rd = (kind_q == BUS_RD);

  always_comb begin
    case (ph_q)
      PH_PRE:  len = T_WHR;
      PH_LOW:  len = is_rd ? T_RL : T_WL;
      PH_HIGH: len = is_rd ? T_RH : T_WH;
      default: len = 1;
    endcase
    last = (cnt_q == CW'(len - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      kind_q <= BUS_CMD;
      byte_q <= '0;
      rd_q   <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (start_i) begin
          kind_q <= kind_i;
          byte_q <= byte_i;
          cnt_q  <= '0;
          ph_q   <= (kind_i == BUS_RD) ? PH_PRE : PH_LOW;
        end
        PH_PRE: begin
          cnt_q <= last ? '0 : cnt_q + 1'b1;
          if (last) ph_q <= PH_LOW;
        end
        PH_LOW: begin
          cnt_q <= last ? '0 : cnt_q + 1'b1;
          if (last) begin
            ph_q <= PH_HIGH;
            if (is_rd) rd_q <= io_i;
          end
        end
        default: begin
          cnt_q <= last ? '0 : cnt_q + 1'b1;
          if (last) ph_q <= PH_IDLE;
        end
      endcase
    end
  end

  logic active;
  assign active    = (ph_q != PH_IDLE);
  assign idle_o    = !active;
  assign done_o    = (ph_q == PH_HIGH) && last;
  assign rd_byte_o = rd_q;
  assign cle_o     = active && (kind_q == BUS_CMD);
  assign ale_o     = active && (kind_q == BUS_ADDR);
  assign we_no     = !((ph_q == PH_LOW) && !is_rd);
  assign re_no     = !((ph_q == PH_LOW) && is_rd);
  assign io_oe_o   = active && !is_rd;
  assign io_o      = io_oe_o ? byte_q : 8'h00;

  p_latch_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o));
  p_strobe_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no && !re_no));
  p_oe_off_in_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_no |-> !io_oe_o);
  p_start_when_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> idle_o);

endmodule

// File: rtl/nand_busy_wait.sv
module nand_busy_wait #(
  parameter int T_WB  = 6,
  parameter int TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             rb_ni,
  input  logic [TMO_W-1:0] limit_i,
  output logic             ready_o,
  output logic             tmo_o,
  output logic             polling_o
);

  localparam int HW = $clog2(T_WB + 1);

  typedef enum logic [1:0] {W_IDLE, W_SETTLE, W_POLL} wstate_e;

  wstate_e          st_q;
  logic [HW-1:0]    hold_q;
  logic [TMO_W-1:0] low_q;

  assign polling_o = (st_q == W_POLL);
  assign ready_o   = polling_o && rb_ni;
  assign tmo_o     = polling_o && !rb_ni && (low_q >= limit_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= W_IDLE;
      hold_q <= '0;
      low_q  <= '0;
    end else begin
      case (st_q)
        W_IDLE: if (arm_i) begin
          st_q   <= W_SETTLE;
          hold_q <= '0;
        end
        W_SETTLE: begin
          hold_q <= hold_q + 1'b1;
          if (hold_q == HW'(T_WB - 1)) begin
            st_q  <= W_POLL;
            low_q <= '0;
          end
        end
        default: begin
          if (ready_o || tmo_o) st_q <= W_IDLE;
          else low_q <= low_q + 1'b1;
        end
      endcase
    end
  end

  p_settle_not_skipped_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == W_SETTLE) |=> (st_q != W_IDLE));
  p_tmo_needs_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (polling_o && rb_ni) |-> !tmo_o);

endmodule

// File: rtl/nand_col_track.sv
module nand_col_track #(
  parameter int MAX_PATCH = 4,
  parameter int COL_W     = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             rec_i,
  input  logic [COL_W-1:0] col_i,
  output logic             hit_o
);

  localparam int PW = (MAX_PATCH > 1) ? $clog2(MAX_PATCH) : 1;

  logic [COL_W-1:0] col_q [MAX_PATCH];
  logic [MAX_PATCH-1:0] vld_q;
  logic [MAX_PATCH-1:0] match;
  logic [PW-1:0] ptr_q;

  for (genvar g = 0; g < MAX_PATCH; g++) begin : g_slot
    assign match[g] = vld_q[g] && (col_q[g] == col_i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        col_q[g] <= '0;
        vld_q[g] <= 1'b0;
      end else if (clear_i) begin
        vld_q[g] <= 1'b0;
      end else if (rec_i && (ptr_q == PW'(g))) begin
        col_q[g] <= col_i;
        vld_q[g] <= 1'b1;
      end
    end
  end

  assign hit_o = |match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (clear_i) ptr_q <= '0;
    else if (rec_i)   ptr_q <= ptr_q + 1'b1;
  end

  p_no_record_on_hit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_i && !clear_i) |=> (vld_q != '0));

endmodule

// File: rtl/nand_move_seq.sv
module nand_move_seq
  import nand_move_pkg::*;
#(
  parameter int ADDR_CYC  = 5,
  parameter int COL_CYC   = 2,
  parameter int MAX_PATCH = 4,
  parameter int TMO_W     = 16,
  parameter int T_WL      = 2,
  parameter int T_WH      = 2,
  parameter int T_WHR     = 3,
  parameter int T_RL      = 2,
  parameter int T_RH      = 2,
  parameter int T_WB      = 6,
  localparam int AW       = 8 * ADDR_CYC,
  localparam int COL_W    = 8 * COL_CYC,
  localparam int CNTW     = $clog2(MAX_PATCH + 1),
  localparam int PIW      = (MAX_PATCH > 1) ? $clog2(MAX_PATCH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [AW-1:0]    src_addr_i,
  input  logic [AW-1:0]    dst_addr_i,
  input  logic             edc_en_i,
  input  logic [CNTW-1:0]  patch_cnt_i,
  output logic [PIW-1:0]   patch_idx_o,
  input  logic [COL_W-1:0] patch_col_i,
  input  logic [7:0]       patch_byte_i,
  input  logic [TMO_W-1:0] tmo_limit_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             prog_fail_o,
  output logic             edc_fail_o,
  output logic             tmo_err_o,
  output logic             dup_err_o,
  output logic             nand_cle_o,
  output logic             nand_ale_o,
  output logic             nand_we_no,
  output logic             nand_re_no,
  output logic [7:0]       nand_io_o,
  output logic             nand_io_oe_o,
  input  logic [7:0]       nand_io_i,
  input  logic             nand_rb_ni
);

  localparam int AIW = $clog2(ADDR_CYC);

  typedef enum logic [4:0] {
    ST_IDLE, ST_SRC_CMD, ST_SRC_ADR, ST_SRC_CFM, ST_SRC_WAIT,
    ST_DST_CMD, ST_DST_ADR, ST_PSEL, ST_P_CMD, ST_P_COL, ST_P_DAT,
    ST_DST_CFM, ST_DST_WAIT, ST_STAT_CMD, ST_STAT_RD, ST_EDC_CMD,
    ST_EDC_RD, ST_DONE
  } seq_e;

  seq_e             st_q;
  logic [AW-1:0]    src_q, dst_q;
  logic             edc_q;
  logic [CNTW-1:0]  cnt_q, pidx_q;
  logic [TMO_W-1:0] lim_q;
  logic [AIW-1:0]   aidx_q;
  logic [COL_W-1:0] pcol_q;
  logic [7:0]       pbyte_q;
  logic             launched_q;

  // Named internal events
  logic       bus_req, bus_done, bus_idle, is_wait, wait_arm;
  logic       wt_ready, wt_tmo, wt_poll, col_hit;
  logic       psel_end, psel_dup, psel_take, accept;
  bus_kind_e  bus_kind;
  logic [7:0] bus_byte, rd_byte;

  assign accept    = (st_q == ST_IDLE) && start_i;
  assign is_wait   = (st_q == ST_SRC_WAIT) || (st_q == ST_DST_WAIT);
  assign wait_arm  = is_wait && !launched_q;
  assign psel_end  = (st_q == ST_PSEL) && (pidx_q == cnt_q);
  assign psel_dup  = (st_q == ST_PSEL) && !psel_end && edc_q && col_hit;
  assign psel_take = (st_q == ST_PSEL) && !psel_end && !psel_dup;

  always_comb begin
    bus_req  = 1'b1;
    bus_kind = BUS_CMD;
    bus_byte = 8'h00;
    case (st_q)
      ST_SRC_CMD:  bus_byte = OP_SRC_LOAD;
      ST_SRC_ADR:  begin bus_kind = BUS_ADDR; bus_byte = pick_byte(64'(src_q), aidx_q); end
      ST_SRC_CFM:  bus_byte = OP_SRC_COMMIT;
      ST_DST_CMD:  bus_byte = OP_DST_OPEN;
      ST_DST_ADR:  begin bus_kind = BUS_ADDR; bus_byte = pick_byte(64'(dst_q), aidx_q); end
      ST_P_CMD:    bus_byte = OP_DST_OPEN;
      ST_P_COL:    begin bus_kind = BUS_ADDR; bus_byte = pick_byte(64'(pcol_q), aidx_q); end
      ST_P_DAT:    begin bus_kind = BUS_DIN; bus_byte = pbyte_q; end
      ST_DST_CFM:  bus_byte = OP_DST_COMMIT;
      ST_STAT_CMD: bus_byte = OP_PROG_STAT;
      ST_STAT_RD:  bus_kind = BUS_RD;
      ST_EDC_CMD:  bus_byte = OP_EDC_STAT;
      ST_EDC_RD:   bus_kind = BUS_RD;
      default:     bus_req  = 1'b0;
    endcase
  end

  nand_bus_cycle #(
    .T_WL(T_WL), .T_WH(T_WH), .T_WHR(T_WHR), .T_RL(T_RL), .T_RH(T_RH)
  ) bus_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (bus_req && !launched_q),
    .kind_i    (bus_kind),
    .byte_i    (bus_byte),
    .done_o    (bus_done),
    .idle_o    (bus_idle),
    .rd_byte_o (rd_byte),
    .cle_o     (nand_cle_o),
    .ale_o     (nand_ale_o),
    .we_no     (nand_we_no),
    .re_no     (nand_re_no),
    .io_o      (nand_io_o),
    .io_oe_o   (nand_io_oe_o),
    .io_i      (nand_io_i)
  );

  nand_busy_wait #(.T_WB(T_WB), .TMO_W(TMO_W)) wait_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (wait_arm),
    .rb_ni     (nand_rb_ni),
    .limit_i   (lim_q),
    .ready_o   (wt_ready),
    .tmo_o     (wt_tmo),
    .polling_o (wt_poll)
  );

  nand_col_track #(.MAX_PATCH(MAX_PATCH), .COL_W(COL_W)) track_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept),
    .rec_i   (psel_take),
    .col_i   (patch_col_i),
    .hit_o   (col_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      src_q       <= '0;
      dst_q       <= '0;
      edc_q       <= 1'b0;
      cnt_q       <= '0;
      pidx_q      <= '0;
      lim_q       <= '0;
      aidx_q      <= '0;
      pcol_q      <= '0;
      pbyte_q     <= '0;
      launched_q  <= 1'b0;
      prog_fail_o <= 1'b0;
      edc_fail_o  <= 1'b0;
      tmo_err_o   <= 1'b0;
      dup_err_o   <= 1'b0;
    end else begin
      if ((bus_req || wait_arm) && !launched_q) launched_q <= 1'b1;
      if (bus_done || wt_ready || wt_tmo) launched_q <= 1'b0;

      case (st_q)
        ST_IDLE: if (start_i) begin
          src_q       <= src_addr_i;
          dst_q       <= dst_addr_i;
          edc_q       <= edc_en_i;
          cnt_q       <= (patch_cnt_i > CNTW'(MAX_PATCH)) ? CNTW'(MAX_PATCH) : patch_cnt_i;
          lim_q       <= tmo_limit_i;
          prog_fail_o <= 1'b0;
          edc_fail_o  <= 1'b0;
          tmo_err_o   <= 1'b0;
          dup_err_o   <= 1'b0;
          st_q        <= ST_SRC_CMD;
        end
        ST_SRC_CMD: if (bus_done) begin aidx_q <= '0; st_q <= ST_SRC_ADR; end
        ST_SRC_ADR: if (bus_done) begin
          aidx_q <= aidx_q + 1'b1;
          if (aidx_q == AIW'(ADDR_CYC - 1)) st_q <= ST_SRC_CFM;
        end
        ST_SRC_CFM: if (bus_done) st_q <= ST_SRC_WAIT;
        ST_SRC_WAIT: begin
          if (wt_ready)    st_q <= ST_DST_CMD;
          else if (wt_tmo) st_q <= ST_DONE;
        end
        ST_DST_CMD: if (bus_done) begin aidx_q <= '0; st_q <= ST_DST_ADR; end
        ST_DST_ADR: if (bus_done) begin
          aidx_q <= aidx_q + 1'b1;
          if (aidx_q == AIW'(ADDR_CYC - 1)) begin
            pidx_q <= '0;
            st_q   <= ST_PSEL;
          end
        end
        ST_PSEL: begin
          if (psel_end) st_q <= ST_DST_CFM;
          else if (psel_dup) begin
            dup_err_o <= 1'b1;
            pidx_q    <= pidx_q + 1'b1;
          end else begin
            pcol_q  <= patch_col_i;
            pbyte_q <= patch_byte_i;
            aidx_q  <= '0;
            st_q    <= ST_P_CMD;
          end
        end
        ST_P_CMD: if (bus_done) st_q <= ST_P_COL;
        ST_P_COL: if (bus_done) begin
          aidx_q <= aidx_q + 1'b1;
          if (aidx_q == AIW'(COL_CYC - 1)) st_q <= ST_P_DAT;
        end
        ST_P_DAT: if (bus_done) begin
          pidx_q <= pidx_q + 1'b1;
          st_q   <= ST_PSEL;
        end
        ST_DST_CFM: if (bus_done) st_q <= ST_DST_WAIT;
        ST_DST_WAIT: begin
          if (wt_ready)    st_q <= ST_STAT_CMD;
          else if (wt_tmo) st_q <= ST_DONE;
        end
        ST_STAT_CMD: if (bus_done) st_q <= ST_STAT_RD;
        ST_STAT_RD: if (bus_done) begin
          prog_fail_o <= stat_fail(rd_byte);
          st_q        <= edc_q ? ST_EDC_CMD : ST_DONE;
        end
        ST_EDC_CMD: if (bus_done) st_q <= ST_EDC_RD;
        ST_EDC_RD: if (bus_done) begin
          edc_fail_o <= stat_fail(rd_byte);
          st_q       <= ST_DONE;
        end
        default: st_q <= ST_IDLE;
      endcase

      if (is_wait && wt_tmo) begin
        tmo_err_o   <= 1'b1;
        prog_fail_o <= 1'b1;
        edc_fail_o  <= 1'b1;
      end
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_DONE);
  assign patch_idx_o = pidx_q[PIW-1:0];

  p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_flags_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable({prog_fail_o, edc_fail_o, tmo_err_o, dup_err_o}));
  p_quiet_in_wait_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_wait |-> (nand_we_no && nand_re_no && bus_idle));
  p_dup_skipped_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psel_dup |=> (st_q == ST_PSEL));
  p_no_edc_query_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_STAT_RD && bus_done && !edc_q) |=> done_o);
  p_tmo_stops_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_wait && wt_tmo) |=> (done_o && tmo_err_o));
  p_start_ignored_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable({src_q, dst_q}));

endmodule

// File: tb/nand_move_seq_tb.sv
module nand_move_seq_tb_top;

  typedef struct packed {
    logic [39:0]      src;
    logic [39:0]      dst;
    logic             edc;
    logic [2:0]       cnt;
    logic [3:0][15:0] cols;
    logic [3:0][7:0]  bytes;
    logic [15:0]      br;
    logic [15:0]      bp;
    logic [15:0]      lim;
    logic [7:0]       s70;
    logic [7:0]       s7b;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{40'h1234_5678_9A, 40'h0102_0304_05, 1'b1, 3'd0, {16'h0, 16'h0, 16'h0, 16'h0},
      {8'h0, 8'h0, 8'h0, 8'h0}, 16'd20, 16'd30, 16'd200, 8'hE0, 8'h00},
    '{40'hA5A5_0000_11, 40'h5A5A_FFFF_22, 1'b1, 3'd2, {16'h0, 16'h0, 16'h0123, 16'h0010},
      {8'h0, 8'h0, 8'h3C, 8'hC3}, 16'd15, 16'd40, 16'd200, 8'hE1, 8'h01},
    '{40'h0000_0000_00, 40'hFFFF_FFFF_FF, 1'b1, 3'd3, {16'h0, 16'h0040, 16'h0200, 16'h0040},
      {8'h0, 8'h77, 8'h66, 8'h55}, 16'd25, 16'd25, 16'd200, 8'hE0, 8'h01},
    '{40'h0011_2233_44, 40'h5566_7788_99, 1'b0, 3'd3, {16'h0, 16'h0040, 16'h0200, 16'h0040},
      {8'h0, 8'h77, 8'h66, 8'h55}, 16'd25, 16'd25, 16'd200, 8'hE0, 8'h01},
    '{40'hDEAD_BEEF_01, 40'hCAFE_F00D_02, 1'b1, 3'd1, {16'h0, 16'h0, 16'h0, 16'h0808},
      {8'h0, 8'h0, 8'h0, 8'h11}, 16'd300, 16'd20, 16'd100, 8'hE0, 8'h00},
    '{40'h1357_9BDF_02, 40'h2468_ACE0_13, 1'b1, 3'd4, {16'h0007, 16'h0300, 16'h0202, 16'h0007},
      {8'h44, 8'h33, 8'h22, 8'h11}, 16'd10, 16'd250, 16'd120, 8'hE0, 8'h00},
    '{40'h8000_0000_7F, 40'h7FFF_FFFF_80, 1'b1, 3'd4, {16'hFFFF, 16'h0840, 16'h0001, 16'h0000},
      {8'hFF, 8'h00, 8'hAA, 8'h5A}, 16'd12, 16'd18, 16'd150, 8'hC0, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [39:0] src_addr = '0, dst_addr = '0;
  logic        edc_en = 1'b0;
  logic [2:0]  patch_cnt = '0;
  logic [1:0]  patch_idx;
  logic [15:0] patch_col;
  logic [7:0]  patch_byte;
  logic [15:0] tmo_limit = 16'd100;
  logic        busy, done, prog_fail, edc_fail, tmo_err, dup_err;
  logic        cle, ale, we_n, re_n, io_oe;
  logic [7:0]  io_out, io_in;
  logic        rb_n = 1'b1;

  vec_t cur = '0;
  logic [7:0] last_cmd = 8'h00;

  int nchk = 0, nerr = 0, cyc = 0;
  int got_n = 0, rd_n = 0, busy_strobe = 0, excl_bad = 0;
  logic [9:0] got [64];
  logic [9:0] exp_l [64];
  int exp_n;
  int exp_rd;
  logic e_pf, e_ef, e_tmo, e_dup;

  always #2.5 clk = ~clk;

  assign patch_col  = cur.cols[patch_idx];
  assign patch_byte = cur.bytes[patch_idx];
  assign io_in      = (last_cmd == 8'h7B) ? cur.s7b : cur.s70;

  nand_move_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .src_addr_i(src_addr), .dst_addr_i(dst_addr), .edc_en_i(edc_en),
    .patch_cnt_i(patch_cnt), .patch_idx_o(patch_idx),
    .patch_col_i(patch_col), .patch_byte_i(patch_byte),
    .tmo_limit_i(tmo_limit), .busy_o(busy), .done_o(done),
    .prog_fail_o(prog_fail), .edc_fail_o(edc_fail),
    .tmo_err_o(tmo_err), .dup_err_o(dup_err),
    .nand_cle_o(cle), .nand_ale_o(ale), .nand_we_no(we_n), .nand_re_no(re_n),
    .nand_io_o(io_out), .nand_io_oe_o(io_oe), .nand_io_i(io_in), .nand_rb_ni(rb_n)
  );

  // Device model: log each write cycle at the WE# rising edge.
  always @(posedge we_n) begin
    if (cle === 1'b1 || ale === 1'b1 || io_oe === 1'b1) begin
      if (got_n < 64) got[got_n] = {(cle ? 2'd1 : (ale ? 2'd2 : 2'd3)), io_out};
      got_n++;
      if (cle && ale) excl_bad++;
      if (!rb_n) busy_strobe++;
      if (cle) last_cmd = io_out;
      if (cle && (io_out == 8'h35 || io_out == 8'h10)) begin
        automatic int len = (io_out == 8'h35) ? int'(cur.br) : int'(cur.bp);
        fork
          begin
            repeat (2) @(posedge clk);
            #1 rb_n = 1'b0;
            repeat (len) @(posedge clk);
            #1 rb_n = 1'b1;
          end
        join_none
      end
    end
  end

  always @(posedge re_n) begin
    rd_n++;
    if (!rb_n) busy_strobe++;
  end

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic push(input logic [1:0] k, input logic [7:0] b);
    exp_l[exp_n] = {k, b};
    exp_n++;
  endtask

  task automatic build_exp(input vec_t v);
    logic [15:0] rec [4];
    int nrec;
    logic seen;
    exp_n = 0; exp_rd = 0; e_tmo = 0; e_dup = 0; e_pf = 0; e_ef = 0; nrec = 0;
    push(2'd1, 8'h00);
    for (int i = 0; i < 5; i++) push(2'd2, 8'((v.src >> (8 * i)) & 40'hFF));
    push(2'd1, 8'h35);
    if (v.br >= v.lim) begin e_tmo = 1; e_pf = 1; e_ef = 1; return; end
    push(2'd1, 8'h85);
    for (int i = 0; i < 5; i++) push(2'd2, 8'((v.dst >> (8 * i)) & 40'hFF));
    for (int k = 0; k < int'(v.cnt); k++) begin
      seen = 0;
      for (int j = 0; j < nrec; j++) if (rec[j] == v.cols[k]) seen = 1;
      if (v.edc && seen) e_dup = 1;
      else begin
        rec[nrec] = v.cols[k]; nrec++;
        push(2'd1, 8'h85);
        push(2'd2, v.cols[k] % 256);
        push(2'd2, v.cols[k] / 256);
        push(2'd3, v.bytes[k]);
      end
    end
    push(2'd1, 8'h10);
    if (v.bp >= v.lim) begin e_tmo = 1; e_pf = 1; e_ef = 1; return; end
    push(2'd1, 8'h70);
    exp_rd = 1;
    e_pf = v.s70[0];
    if (v.edc) begin push(2'd1, 8'h7B); exp_rd = 2; e_ef = v.s7b[0]; end
  endtask

  task automatic run_vec(input vec_t v, input logic poke);
    int w;
    logic same;
    logic [3:0] held;
    cur = v;
    build_exp(v);
    @(negedge clk);
    got_n = 0; rd_n = 0; busy_strobe = 0; excl_bad = 0;
    src_addr = v.src; dst_addr = v.dst; edc_en = v.edc;
    patch_cnt = v.cnt; tmo_limit = v.lim;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (30) @(negedge clk);
      src_addr = ~v.src; dst_addr = ~v.dst; start = 1'b1;
      @(negedge clk);
      start = 1'b0; src_addr = v.src; dst_addr = v.dst;
    end
    w = 0;
    while (!done && w < 5000) begin @(negedge clk); w++; end
    check(done === 1'b1, "R9 done pulse seen", done, 1);
    check(got_n == exp_n, "R1/R3 bus cycle count", got_n, exp_n);
    same = 1;
    for (int i = 0; i < exp_n && i < 64; i++) if (got[i] !== exp_l[i]) same = 0;
    check(same, poke ? "R12 sequence after ignored start" : "R1 R3 R4 R5 bus sequence", same, 1);
    check(rd_n == exp_rd, "R6 R7 read cycle count", rd_n, exp_rd);
    check(prog_fail === e_pf, "R6 prog_fail", prog_fail, e_pf);
    check(edc_fail === e_ef, "R7 edc_fail", edc_fail, e_ef);
    check(tmo_err === e_tmo, "R8 tmo_err", tmo_err, e_tmo);
    check(dup_err === e_dup, "R5 dup_err", dup_err, e_dup);
    check(busy_strobe == 0, "R2 strobe during busy", busy_strobe, 0);
    check(excl_bad == 0, "R10 CLE ALE exclusive", excl_bad, 0);
    held = {prog_fail, edc_fail, tmo_err, dup_err};
    @(negedge clk);
    check(done === 1'b0, "R9 done one cycle", done, 0);
    cur.s70 = ~v.s70; cur.s7b = ~v.s7b;
    repeat (6) @(negedge clk);
    check({prog_fail, edc_fail, tmo_err, dup_err} === held, "R9 flags held",
          {prog_fail, edc_fail, tmo_err, dup_err}, held);
    while (!rb_n) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nerr++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, done, we_n, re_n, cle, ale, io_oe} === 7'b0011000, "R11 reset state",
          {busy, done, we_n, re_n, cle, ale, io_oe}, 7'b0011000);
    for (int v = 0; v < NV; v++) run_vec(VECS[v], 1'b0);
    run_vec(VECS[1], 1'b1);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule